// File: doc/BRIEF.md
# MDIO Management Master (Clause 22 and Clause 45)

This block lets software reach the management registers of Ethernet PHYs over the two-wire MDIO bus. It generates the management clock, MDC, from the system clock using a programmable divider. It serialises command frames onto the MDIO data line, releases the line during the read turnaround so that the PHY can drive it, and collects the sixteen bits that the PHY returns. One configuration bit selects the frame format. Clause 22 frames address a PHY and one of its 32 registers. Clause 45 frames address a PHY and a device inside it, and use a separate address frame to set a 16-bit register pointer.

Software sees four 32-bit words at word offsets 12 to 15. Offsets 0 to 11 are reserved and read as zero. Writing a word starts a frame: the address word starts a Clause 45 address frame, the data word starts a write frame, and a command word with its read bit set starts a read frame. A busy flag stays high until the frame has finished on the wire. Writes that arrive while busy is high are dropped. When the PHY leaves the turnaround high during a read, the block sets a read-error flag and, by default, substitutes all ones for the returned data.

Top module: `mgmt_mdio_master`

## Requirements
- R1: Out of reset every word (config 12, command 13, data 14, address 15) reads zero, MDC is low and the MDIO output enable is low; reserved offsets always read zero.
- R2: Config word fields: bit 0 busy (read-only), bit 1 read error (read-only), bit 6 selects Clause 45 when 1, bits 15:8 hold the divider D; bit 6 and the divider read back as written.
- R3: While a frame runs, MDC has a period of 2*(D+1) system clocks and one rising edge per frame bit; MDC is low whenever no frame runs.
- R4: A frame is sent MSB first as: 32 ones of preamble (left out when command bit 10 is set), start code, opcode, port address (command bits 9:5), device or register address (command bits 4:0), turnaround 10, then 16 data bits. Start+opcode are 0101 for a Clause 22 write, 0110 for a Clause 22 read, 0000 for a Clause 45 address frame, 0001 for a Clause 45 write and 0011 for a Clause 45 read.
- R5: In Clause 45 mode a write to the address word sends an address frame that carries bits 15:0 of that word; in Clause 22 mode the write only stores the value and starts no frame.
- R6: A write to the data word sends a write frame that carries bits 15:0 of that word.
- R7: A write to the command word with bit 15 set sends a read frame; once busy clears, data bits 15:0 hold the 16 bits sampled on the MDC rising edges of the data phase.
- R8: The MDIO output enable is high for every bit of address and write frames, low for the two turnaround bits and the 16 data bits of a read frame, and low while idle.
- R9: If MDIO is high at the MDC rising edge of the second turnaround bit of a read, read error becomes 1 and the data word returns 16'hFFFF; read error returns to 0 when the next read frame starts.
- R10: Busy rises in the cycle after the launching write and stays high for exactly 1 + N*2*(D+1) cycles, where N is 64 with preamble and 32 without; bit 31 of the data word mirrors busy.
- R11: Every register write that the block samples while busy is high is discarded, including a write in the final busy cycle; a write in the first cycle after busy falls is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 4 | Word offset of the write |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | 4 | Word offset of the read |
| reg_rdata | output | 32 | Read data (combinational) |
| mdc | output | 1 | Management clock |
| mdio_i | input | 1 | MDIO line as seen at the pad |
| mdio_o | output | 1 | MDIO value driven while enabled |
| mdio_oe | output | 1 | MDIO output enable |

## Verification
The delicate overlap is between a software write and the end of a frame. In the last busy cycle the engine drops busy and, for a read, loads the captured data into the data word, while a write to that same word can be sampled in the same cycle. The bench counts cycles from the launching write and places a data-word write exactly on the final busy edge, then one edge later. It requires the first write to leave the stored value unchanged with no new frame, and the second to store its value and raise busy again. The bus-facing behaviour is checked with a PHY model that records every bit at the MDC rising edge and compares it with frames built from the field values.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

   // word offsets of the software-visible registers
   localparam logic [3:0] OFS_CFG = 4'd12;
   localparam logic [3:0] OFS_CMD = 4'd13;
   localparam logic [3:0] OFS_DAT = 4'd14;
   localparam logic [3:0] OFS_ADR = 4'd15;

   // payload and header geometry of one frame without preamble
   localparam int BODY_BITS = 32;
   localparam int DATA_BITS = 16;

   typedef enum logic [1:0] {
      OP_ADDR  = 2'd0,
      OP_WRITE = 2'd1,
      OP_READ  = 2'd2
   } mdio_op_e;

   // start code followed by opcode, four bits sent first after the preamble
   function automatic logic [3:0] frame_code(input logic c45, input mdio_op_e op);
      logic [3:0] code;
      if (c45) begin
         case (op)
            OP_ADDR:  code = 4'b0000;
            OP_WRITE: code = 4'b0001;
            default:  code = 4'b0011;
         endcase
      end else begin
         case (op)
            OP_READ: code = 4'b0110;
            default: code = 4'b0101;
         endcase
      end
      return code;
   endfunction

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             mdc,
   output logic             rise_stb,
   output logic             fall_stb
);

   logic [DIV_W-1:0] cnt_q;
   logic             wrap;

   // half period elapses when the counter reaches the divider value
   assign wrap     = run && (cnt_q == div);
   assign rise_stb = wrap && !mdc;
   assign fall_stb = wrap && mdc;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         mdc   <= 1'b0;
      end else if (!run) begin
         cnt_q <= '0;
         mdc   <= 1'b0;
      end else if (wrap) begin
         cnt_q <= '0;
         mdc   <= ~mdc;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
   import mdio_pkg::*;
#(
   parameter int PRE_BITS = 32
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   input  mdio_op_e    op,
   input  logic        c45,
   input  logic        pre_dis,
   input  logic [4:0]  port,
   input  logic [4:0]  dev,
   input  logic [15:0] payload,
   input  logic        rise_stb,
   input  logic        fall_stb,
   input  logic        mdio_i,
   output logic        busy,
   output logic        mdio_o,
   output logic        mdio_oe,
   output logic        err_stb,
   output logic        rd_done,
   output logic [15:0] rd_data
);

   localparam int FRAME_BITS = PRE_BITS + BODY_BITS;
   localparam int IDX_W      = $clog2(FRAME_BITS);
   localparam logic [IDX_W-1:0] IDX_TA_HI = IDX_W'(DATA_BITS + 1);
   localparam logic [IDX_W-1:0] IDX_TA_LO = IDX_W'(DATA_BITS);
   localparam logic [IDX_W-1:0] IDX_FULL  = IDX_W'(FRAME_BITS - 1);
   localparam logic [IDX_W-1:0] IDX_SHORT = IDX_W'(BODY_BITS - 1);

   logic [FRAME_BITS-1:0] frame_q;
   logic [IDX_W-1:0]      idx_q;
   logic                  busy_q;
   mdio_op_e              op_q;
   logic [15:0]           cap_q;
   logic [BODY_BITS-1:0]  body;
   logic                  is_rd;
   logic                  last_bit;

   assign body = {frame_code(c45, op), port, dev,
                  (op == OP_READ) ? 2'b11 : 2'b10, payload};

   assign is_rd    = (op_q == OP_READ);
   assign last_bit = (idx_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         frame_q <= '0;
         idx_q   <= '0;
         busy_q  <= 1'b0;
         op_q    <= OP_ADDR;
         cap_q   <= '0;
      end else if (start && !busy_q) begin
         frame_q <= {{PRE_BITS{1'b1}}, body};
         idx_q   <= pre_dis ? IDX_SHORT : IDX_FULL;
         busy_q  <= 1'b1;
         op_q    <= op;
      end else if (busy_q) begin
         if (rise_stb && is_rd && (idx_q < IDX_TA_LO))
            cap_q <= {cap_q[14:0], mdio_i};
         if (fall_stb) begin
            if (last_bit) busy_q <= 1'b0;
            else          idx_q  <= idx_q - 1'b1;
         end
      end
   end

   assign busy    = busy_q;
   assign mdio_o  = busy_q ? frame_q[idx_q] : 1'b1;
   assign mdio_oe = busy_q && !(is_rd && (idx_q <= IDX_TA_HI));
   assign err_stb = busy_q && rise_stb && is_rd && (idx_q == IDX_TA_LO) && mdio_i;
   assign rd_done = busy_q && fall_stb && last_bit && is_rd;
   assign rd_data = cap_q;

endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
   import mdio_pkg::*;
#(
   parameter int DIV_W    = 8,
   parameter bit ERR_FILL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_we,
   input  logic [3:0]       reg_waddr,
   input  logic [31:0]      reg_wdata,
   input  logic [3:0]       reg_raddr,
   output logic [31:0]      reg_rdata,
   input  logic             eng_busy,
   input  logic             err_stb,
   input  logic             rd_done,
   input  logic [15:0]      rd_data,
   output logic             launch,
   output mdio_op_e         launch_op,
   output logic             c45,
   output logic             pre_dis,
   output logic [4:0]       port,
   output logic [4:0]       dev,
   output logic [15:0]      payload,
   output logic [DIV_W-1:0] div,
   output logic             busy_all,
   output logic [15:0]      data_val,
   output logic             rd_err
);

   localparam int CFG_ENC_BIT = 6;
   localparam int CFG_DIV_LSB = 8;
   localparam int CMD_PRE_BIT = 10;
   localparam int CMD_RD_BIT  = 15;

   logic             c45_q;
   logic [DIV_W-1:0] div_q;
   logic [15:0]      cmd_q;
   logic [15:0]      dat_q;
   logic [15:0]      adr_q;
   logic             rderr_q;
   logic             launch_q;
   mdio_op_e         lop_q;
   logic             accept;
   logic [15:0]      rd_store;
   logic             unused_wdata;

   assign unused_wdata = ^reg_wdata[31:16];
   assign busy_all     = eng_busy | launch_q;
   assign accept       = reg_we && !busy_all;

   generate
      if (ERR_FILL) begin : g_fill
         assign rd_store = rderr_q ? 16'hFFFF : rd_data;
      end else begin : g_raw
         assign rd_store = rd_data;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         c45_q    <= 1'b0;
         div_q    <= '0;
         cmd_q    <= '0;
         dat_q    <= '0;
         adr_q    <= '0;
         rderr_q  <= 1'b0;
         launch_q <= 1'b0;
         lop_q    <= OP_ADDR;
      end else begin
         launch_q <= 1'b0;
         if (accept) begin
            case (reg_waddr)
               OFS_CFG: begin
                  c45_q <= reg_wdata[CFG_ENC_BIT];
                  div_q <= reg_wdata[CFG_DIV_LSB +: DIV_W];
               end
               OFS_CMD: begin
                  cmd_q <= reg_wdata[15:0];
                  if (reg_wdata[CMD_RD_BIT]) begin
                     launch_q <= 1'b1;
                     lop_q    <= OP_READ;
                  end
               end
               OFS_DAT: begin
                  dat_q    <= reg_wdata[15:0];
                  launch_q <= 1'b1;
                  lop_q    <= OP_WRITE;
               end
               OFS_ADR: begin
                  adr_q <= reg_wdata[15:0];
                  if (c45_q) begin
                     launch_q <= 1'b1;
                     lop_q    <= OP_ADDR;
                  end
               end
               default: ;
            endcase
         end
         if (launch_q && (lop_q == OP_READ)) rderr_q <= 1'b0;
         if (err_stb)                        rderr_q <= 1'b1;
         if (rd_done)                        dat_q   <= rd_store;
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_raddr)
         OFS_CFG: begin
            reg_rdata[0]                        = busy_all;
            reg_rdata[1]                        = rderr_q;
            reg_rdata[CFG_ENC_BIT]              = c45_q;
            reg_rdata[CFG_DIV_LSB +: DIV_W]     = div_q;
         end
         OFS_CMD: reg_rdata = {16'h0, cmd_q};
         OFS_DAT: reg_rdata = {busy_all, 15'h0, dat_q};
         OFS_ADR: reg_rdata = {16'h0, adr_q};
         default: reg_rdata = '0;
      endcase
   end

   assign launch    = launch_q;
   assign launch_op = lop_q;
   assign c45       = c45_q;
   assign pre_dis   = cmd_q[CMD_PRE_BIT];
   assign port      = cmd_q[9:5];
   assign dev       = cmd_q[4:0];
   assign payload   = (lop_q == OP_ADDR) ? adr_q : dat_q;
   assign div       = div_q;
   assign data_val  = dat_q;
   assign rd_err    = rderr_q;

endmodule

// File: rtl/mgmt_mdio_master.sv
module mgmt_mdio_master
   import mdio_pkg::*;
#(
   parameter int DIV_W    = 8,
   parameter int PRE_BITS = 32,
   parameter bit ERR_FILL = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_we,
   input  logic [3:0]  reg_waddr,
   input  logic [31:0] reg_wdata,
   input  logic [3:0]  reg_raddr,
   output logic [31:0] reg_rdata,
   output logic        mdc,
   input  logic        mdio_i,
   output logic        mdio_o,
   output logic        mdio_oe
);

   generate
      if (DIV_W < 1 || DIV_W > 8) begin : g_bad_div
         $error("DIV_W must lie in 1..8 to fit config bits 15:8");
      end
      if (PRE_BITS < 1 || PRE_BITS > 64) begin : g_bad_pre
         $error("PRE_BITS must lie in 1..64");
      end
   endgenerate

   logic             launch;
   mdio_op_e         launch_op;
   logic             c45;
   logic             pre_dis;
   logic [4:0]       port;
   logic [4:0]       dev;
   logic [15:0]      payload;
   logic [DIV_W-1:0] div;
   logic             busy_all;
   logic [15:0]      data_val;
   logic             rd_err;
   logic             eng_busy;
   logic             err_stb;
   logic             rd_done;
   logic [15:0]      rd_data;
   logic             rise_stb;
   logic             fall_stb;

   mdio_regs #(.DIV_W(DIV_W), .ERR_FILL(ERR_FILL)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_we    (reg_we),
      .reg_waddr (reg_waddr),
      .reg_wdata (reg_wdata),
      .reg_raddr (reg_raddr),
      .reg_rdata (reg_rdata),
      .eng_busy  (eng_busy),
      .err_stb   (err_stb),
      .rd_done   (rd_done),
      .rd_data   (rd_data),
      .launch    (launch),
      .launch_op (launch_op),
      .c45       (c45),
      .pre_dis   (pre_dis),
      .port      (port),
      .dev       (dev),
      .payload   (payload),
      .div       (div),
      .busy_all  (busy_all),
      .data_val  (data_val),
      .rd_err    (rd_err)
   );

   mdio_clkgen #(.DIV_W(DIV_W)) u_clkgen (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (eng_busy),
      .div      (div),
      .mdc      (mdc),
      .rise_stb (rise_stb),
      .fall_stb (fall_stb)
   );

   mdio_frame_eng #(.PRE_BITS(PRE_BITS)) u_eng (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (launch),
      .op       (launch_op),
      .c45      (c45),
      .pre_dis  (pre_dis),
      .port     (port),
      .dev      (dev),
      .payload  (payload),
      .rise_stb (rise_stb),
      .fall_stb (fall_stb),
      .mdio_i   (mdio_i),
      .busy     (eng_busy),
      .mdio_o   (mdio_o),
      .mdio_oe  (mdio_oe),
      .err_stb  (err_stb),
      .rd_done  (rd_done),
      .rd_data  (rd_data)
   );

endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk
   import mdio_pkg::*;
(
   input logic        clk,
   input logic        rst_n,
   input logic        eng_busy,
   input logic        busy_all,
   input logic        mdc,
   input logic        mdio_oe,
   input logic        reg_we,
   input logic [3:0]  reg_waddr,
   input logic [15:0] data_val,
   input logic        rd_done,
   input logic        launch,
   input mdio_op_e    launch_op,
   input logic        rd_err
);

   assert_oe_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !eng_busy |-> !mdio_oe);

   assert_mdc_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !eng_busy |-> !mdc);

   assert_mdc_moves_in_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mdc) |-> $past(eng_busy));

   assert_busy_write_dropped_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_all && reg_we && (reg_waddr == OFS_DAT) && !rd_done) |=> $stable(data_val));

   assert_err_clear_on_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (launch && (launch_op == OP_READ)) |=> !rd_err);

   assert_launch_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      launch |-> !eng_busy);

endmodule

bind mgmt_mdio_master mdio_master_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .eng_busy  (eng_busy),
   .busy_all  (busy_all),
   .mdc       (mdc),
   .mdio_oe   (mdio_oe),
   .reg_we    (reg_we),
   .reg_waddr (reg_waddr),
   .data_val  (data_val),
   .rd_done   (rd_done),
   .launch    (launch),
   .launch_op (launch_op),
   .rd_err    (rd_err)
);

// File: tb/mgmt_mdio_master_bench.sv
module mgmt_mdio_master_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [3:0]  reg_waddr = '0;
   logic [31:0] reg_wdata = '0;
   logic [3:0]  reg_raddr = '0;
   logic [31:0] reg_rdata;
   logic        mdc;
   logic        mdio_i = 1'b1;
   logic        mdio_o;
   logic        mdio_oe;

   int     n_chk = 0;
   int     n_fail = 0;
   longint cyc = 0;

   always #4 clk = ~clk;
   always @(posedge clk) cyc++;

   mgmt_mdio_master u_mgmt_mdio_master (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_we    (reg_we),
      .reg_waddr (reg_waddr),
      .reg_wdata (reg_wdata),
      .reg_raddr (reg_raddr),
      .reg_rdata (reg_rdata),
      .mdc       (mdc),
      .mdio_i    (mdio_i),
      .mdio_o    (mdio_o),
      .mdio_oe   (mdio_oe)
   );

   // PHY model: records bits on MDC rise, answers reads after MDC fall
   int          rise_cnt = 0;
   int          phy_n = 64;
   logic        phy_ta_low = 1'b1;
   logic [15:0] phy_resp = '0;
   logic [63:0] cap_o = '0;
   logic [63:0] cap_oe = '0;
   longint      last_rise = 0;
   longint      rise_gap = 0;

   always @(posedge mdc) begin
      cap_o     = {cap_o[62:0], mdio_o};
      cap_oe    = {cap_oe[62:0], mdio_oe};
      rise_gap  = cyc - last_rise;
      last_rise = cyc;
      rise_cnt++;
   end

   always @(negedge mdc) begin
      if (rise_cnt == phy_n - 17)
         mdio_i = phy_ta_low ? 1'b0 : 1'b1;
      else if (rise_cnt >= phy_n - 16 && rise_cnt < phy_n)
         mdio_i = phy_resp[phy_n - 1 - rise_cnt];
      else
         mdio_i = 1'b1;
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we    = 1'b1;
      reg_waddr = a;
      reg_wdata = d;
      @(negedge clk);
      reg_we    = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      reg_raddr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic wait_idle();
      logic [31:0] r;
      int guard;
      guard = 0;
      rd(4'd12, r);
      while (r[0] && guard < 20000) begin
         guard++;
         @(negedge clk);
         rd(4'd12, r);
      end
   endtask

   function automatic logic [3:0] exp_code(input int op, input logic c45);
      if (c45) return (op == 0) ? 4'b0000 : (op == 1) ? 4'b0001 : 4'b0011;
      return (op == 2) ? 4'b0110 : 4'b0101;
   endfunction

   // op: 0 address frame, 1 write frame, 2 read frame
   task automatic run_op(input int op, input logic c45, input logic pre_dis,
                         input logic [4:0] port, input logic [4:0] dev,
                         input logic [15:0] val, input int d, input logic ta_low);
      logic [31:0] r;
      logic [31:0] ctl;
      logic [31:0] body;
      logic [63:0] expf;
      logic [63:0] mask;
      logic [63:0] cmask;
      int n;
      int nb;
      wr(4'd12, (32'(c45) << 6) | (32'(d) << 8));
      ctl = (32'(pre_dis) << 10) | (32'(port) << 5) | 32'(dev);
      wr(4'd13, ctl);
      nb = pre_dis ? 32 : 64;
      phy_n = nb; phy_ta_low = ta_low; phy_resp = val;
      rise_cnt = 0; cap_o = '0; cap_oe = '0;
      case (op)
         0:       wr(4'd15, {16'h0, val});
         1:       wr(4'd14, {16'h0, val});
         default: wr(4'd13, ctl | 32'h8000);
      endcase
      n = 0;
      rd(4'd12, r);
      while (r[0] && n < 20000) begin
         n++;
         @(negedge clk);
         rd(4'd12, r);
      end
      chk(n == 1 + nb * 2 * (d + 1), "R10 busy length", n, 1 + nb * 2 * (d + 1));
      chk(rise_cnt == nb, "R3 MDC rises per frame", rise_cnt, nb);
      chk(rise_gap == 2 * (d + 1), "R3 MDC period", rise_gap, 2 * (d + 1));
      chk(!mdc && !mdio_oe, "R8 idle lines", {mdc, mdio_oe}, 0);
      body  = {exp_code(op, c45), port, dev, 2'b10, val};
      expf  = {32'hFFFF_FFFF, body};
      mask  = (nb == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
      cmask = (op == 2) ? (mask & ~64'h3FFFF) : mask;
      if (op == 0)
         chk((cap_o & cmask) == (expf & cmask), "R5 address frame bits", cap_o & cmask, expf & cmask);
      else if (op == 1)
         chk((cap_o & cmask) == (expf & cmask), "R6 write frame bits", cap_o & cmask, expf & cmask);
      else
         chk((cap_o & cmask) == (expf & cmask), "R4 read header bits", cap_o & cmask, expf & cmask);
      chk((cap_oe & mask) == cmask, "R8 output enable per bit", cap_oe & mask, cmask);
      if (op == 2) begin
         rd(4'd14, r);
         chk(r[15:0] == (ta_low ? val : 16'hFFFF), "R7 R9 read data", r[15:0], ta_low ? val : 16'hFFFF);
         rd(4'd12, r);
         chk(r[1] == !ta_low, "R9 read error flag", r[1], !ta_low);
      end else if (op == 1) begin
         rd(4'd14, r);
         chk(r == {16'h0, val}, "R6 data word keeps value", r, {16'h0, val});
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] r;
      int i;
      int dsel;
      int ops;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset values
      for (int a = 0; a < 16; a++) begin
         rd(4'(a), r);
         chk(r == 32'h0, "R1 reset word", r, 0);
      end
      chk(!mdc && !mdio_oe, "R1 reset lines", {mdc, mdio_oe}, 0);

      // R2 config fields
      wr(4'd12, 32'h0000_A543);
      rd(4'd12, r);
      chk(r == 32'h0000_A540, "R2 config readback", r, 32'h0000_A540);
      wr(4'd12, 32'h0);

      // R5 address word in Clause 22 mode only stores
      wr(4'd15, 32'h0000_4321);
      rd(4'd12, r);
      chk(r[0] == 1'b0, "R5 no frame in clause 22", r[0], 0);
      rd(4'd15, r);
      chk(r == 32'h0000_4321, "R5 address stored", r, 32'h4321);
      repeat (4) @(negedge clk);
      chk(rise_cnt == 0, "R5 no MDC activity", rise_cnt, 0);

      // sweep over format, preamble, divider and operation
      i = 0;
      for (int c = 0; c < 2; c++) begin
         for (int p = 0; p < 2; p++) begin
            for (dsel = 0; dsel < 2; dsel++) begin
               ops = (c == 1) ? 3 : 2;
               for (int k = 0; k < ops; k++) begin
                  i++;
                  run_op((c == 1) ? k : k + 1, c[0], p[0], 5'((i * 5 + 1) & 31),
                         5'((i * 3 + 7) & 31), 16'h8000 ^ 16'(i * 16'h1357),
                         dsel * 2, 1'b1);
               end
            end
         end
      end

      // R9 turnaround left high, then a good read clears the flag
      run_op(2, 1'b0, 1'b1, 5'd9, 5'd2, 16'h1111, 0, 1'b0);
      run_op(2, 1'b0, 1'b1, 5'd9, 5'd3, 16'h2222, 0, 1'b1);
      run_op(2, 1'b1, 1'b0, 5'd30, 5'd31, 16'h0001, 1, 1'b0);
      run_op(2, 1'b1, 1'b1, 5'd30, 5'd31, 16'hFFFE, 1, 1'b1);

      // R11 writes in the middle of a frame are dropped; R10 busy mirror
      wr(4'd12, 32'h0000_0100);
      wr(4'd13, 32'h0000_0000);
      wr(4'd14, 32'h0000_1234);
      repeat (20) @(negedge clk);
      rd(4'd14, r);
      chk(r[31] == 1'b1, "R10 data word busy bit", r[31], 1);
      wr(4'd14, 32'h0000_BEEF);
      wr(4'd12, 32'h0000_0540);
      wr(4'd13, 32'h0000_8000);
      wait_idle();
      rd(4'd14, r);
      chk(r == 32'h0000_1234, "R11 data write dropped", r, 32'h1234);
      rd(4'd12, r);
      chk(r == 32'h0000_0100, "R11 config write dropped", r, 32'h100);
      rd(4'd13, r);
      chk(r == 32'h0, "R11 command write dropped", r, 0);
      repeat (5) @(negedge clk);
      rd(4'd12, r);
      chk(r[0] == 1'b0, "R11 no frame from dropped write", r[0], 0);

      // R11 write landing on the final busy edge, then one edge later
      wr(4'd12, 32'h0);
      wr(4'd13, 32'h0000_0400);
      wr(4'd14, 32'h0000_0F0F);
      repeat (64) @(negedge clk);
      reg_we = 1'b1; reg_waddr = 4'd14; reg_wdata = 32'h0000_A5A5;
      @(negedge clk);
      reg_we = 1'b0;
      rd(4'd12, r);
      chk(r[0] == 1'b0, "R11 final-cycle write starts nothing", r[0], 0);
      rd(4'd14, r);
      chk(r == 32'h0000_0F0F, "R11 final-cycle write dropped", r, 32'h0F0F);
      wr(4'd14, 32'h0000_0F0F);
      repeat (65) @(negedge clk);
      reg_we = 1'b1; reg_waddr = 4'd14; reg_wdata = 32'h0000_5A5A;
      @(negedge clk);
      reg_we = 1'b0;
      rd(4'd12, r);
      chk(r[0] == 1'b1, "R11 first idle-cycle write accepted", r[0], 1);
      rd(4'd14, r);
      chk(r[15:0] == 16'h5A5A, "R11 first idle-cycle value", r[15:0], 16'h5A5A);
      wait_idle();

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule